// File: doc/BRIEF.md
# Chunked flash read sequencer

This block copies a byte range out of a serial flash into a word-addressed buffer by driving the register port of a flash command engine. A transfer begins with a one-cycle `start` pulse carrying a byte address and a byte count. The sequencer first takes a hardware semaphore that it shares with other agents, retrying after a programmable delay. It then cuts the range into pieces that never cross a FIFO-sized boundary of the absolute flash address. For every piece it empties stale words from the engine FIFO, reads the flash status register through the engine and refuses to go on while a write is in progress, issues a fast read, waits for the engine's active bit to fall, and drains the FIFO into the buffer with every word byte-swapped.

Every exit after the semaphore was taken gives the semaphore back before `done` is raised. `done` is a one-cycle pulse that comes with a 3-bit result code: 0 ok, 1 length error, 2 FIFO count stuck, 3 write in progress (or the status read found the FIFO empty twice), 4 engine active timeout, 5 semaphore never granted.

The register port is a request/acknowledge stream: the sequencer holds `reg_valid`, `reg_write`, `reg_sel` and `reg_wdata` steady until `reg_ready` is seen, and read data on `reg_rdata` is taken in the same cycle as the handshake. The buffer port is valid/ready: `buf_valid`, `buf_addr` and `buf_data` stay steady while `buf_ready` is low, and the sequencer reads nothing more from the engine until the pending word is accepted. Register selects: 0 semaphore, 1 command, 2 address, 3 device status, 4 read data. Command word: bits [7:0] opcode, [11:8] address byte count, [19:12] read byte count, bit 31 active. The device status register carries the FIFO word count in bits [5:0]; the address register takes the byte address in its low bits.

Top module: `flash_chunk_reader`

## Requirements
- R1: The semaphore is taken by reading select 0; a value of 0 means granted. A non-zero value starts a wait of RETRY_DLY cycles before the next read. After SEM_TRIES reads without a grant the transfer ends with code 5 and no write to the semaphore.
- R2: Each piece is as long as the distance from the current address to the next FIFO_BYTES (128) byte boundary, limited to the bytes still to copy; the fast-read command carries that length in its read byte count, and the pieces follow each other in address order.
- R3: A piece length that is zero, above FIFO_BYTES or not a multiple of 4 ends the transfer with code 1, without any fast read or buffer write.
- R4: Before every status read the FIFO count (status bits [5:0]) is read, that many words are read from select 4 and thrown away, and the count is polled until it is zero; after FLUSH_POLLS non-zero polls the transfer ends with code 2.
- R5: A status read writes command opcode 0x05 with read byte count 4 and address count 0, waits for the active bit, then reads the FIFO count; a count of zero counts as busy and the whole status read (with its flush) is repeated once; a second empty result ends the transfer with code 3.
- R6: The flash status byte is bits [31:24] of the word read from select 4; when its bit 0 (write in progress) is set, the transfer ends with code 3 before any fast read.
- R7: A fast read writes the piece address to select 2, then command opcode 0x0B with address count 4 and active set, then polls the active bit (bit 31 of select 1); after ACT_POLLS polls that still see it set the transfer ends with code 4.
- R8: Each drained word is byte-reversed (byte 0 of the stored word is byte 3 of the read word) and presented at consecutive buffer word addresses starting at 0; a word not accepted stays unchanged on the buffer port.
- R9: Every exit after a grant writes 0 to select 0 before `done`; `done` lasts one cycle and `err_code` is 0 on success; a zero byte count still takes and gives back the semaphore and returns 0.
- R10: A register request is held unchanged until `reg_ready`; after reset no request, no buffer word and no `done` are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle transfer request, taken only while idle |
| start_addr | input | ADDR_W | First flash byte address |
| start_len | input | LEN_W | Number of bytes to copy |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_code | output | 3 | Result code, valid with done |
| reg_valid | output | 1 | Register request present |
| reg_write | output | 1 | 1 write, 0 read |
| reg_sel | output | 3 | Register select |
| reg_wdata | output | 32 | Write data |
| reg_ready | input | 1 | Request accepted this cycle |
| reg_rdata | input | 32 | Read data, valid with the handshake |
| buf_valid | output | 1 | Buffer word present |
| buf_ready | input | 1 | Buffer accepts the word |
| buf_addr | output | LEN_W-2 | Buffer word address |
| buf_data | output | 32 | Byte-swapped word |

## Verification
The checks take for granted that the engine grants the semaphore only on a read that returns 0 and that `start` arrives only while the sequencer is idle, so a semaphore release or a buffer word seen while no grant is outstanding is a design fault. The piece check relies on the address register being written before each fast-read command, which the engine model records. The stimulus raises `start` only after the previous `done`, answers every register request with a model that keeps its semaphore, FIFO and active-bit state consistent, and inserts stalls on both the register port and the buffer port to exercise the hold rules.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [2:0] {
    FC_OK       = 3'd0,
    FC_ERR_LEN  = 3'd1,
    FC_ERR_FIFO = 3'd2,
    FC_ERR_WIP  = 3'd3,
    FC_ERR_ACT  = 3'd4,
    FC_ERR_SEM  = 3'd5
  } fc_err_e;

  typedef enum logic [2:0] {
    SEL_SEM  = 3'd0,
    SEL_CMD  = 3'd1,
    SEL_ADDR = 3'd2,
    SEL_STAT = 3'd3,
    SEL_DATA = 3'd4
  } fc_sel_e;

  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_FAST   = 8'h0B;
  localparam int         ACT_BIT   = 31;
  localparam int         RCNT_LSB  = 12;
  localparam int         OP_LSB    = 0;

  // command word: active | reserved | read bytes | address bytes | opcode
  function automatic logic [31:0] fc_cmd(input logic [7:0] op,
                                         input logic [3:0] acnt,
                                         input logic [7:0] rcnt);
    return {1'b1, 11'b0, rcnt, acnt, op};
  endfunction

endpackage

// File: rtl/fc_piece_calc.sv
module fc_piece_calc #(
  parameter int LEN_W      = 16,
  parameter int FIFO_BYTES = 128,
  localparam int OW = $clog2(FIFO_BYTES),
  localparam int PW = OW + 1
) (
  input  logic [OW-1:0]    addr_lo,
  input  logic [LEN_W-1:0] remain,
  output logic [PW-1:0]    piece_len,
  output logic             piece_bad
);

  logic [PW-1:0] to_edge;
  logic          fits;

  always_comb begin
    to_edge   = PW'(FIFO_BYTES) - {1'b0, addr_lo};
    fits      = remain < LEN_W'(to_edge);
    piece_len = fits ? remain[PW-1:0] : to_edge;
    piece_bad = (piece_len == '0) || (piece_len > PW'(FIFO_BYTES)) ||
                (piece_len[1:0] != 2'b00);
  end

endmodule

// File: rtl/fc_byte_swap.sv
module fc_byte_swap #(
  parameter int BYTES = 4
) (
  input  logic [8*BYTES-1:0] din,
  output logic [8*BYTES-1:0] dout
);

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign dout[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
  end

endmodule

// File: rtl/fc_delay_ctr.sv
module fc_delay_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (run) count <= count + 1'b1;
    else          count <= '0;
  end

endmodule

// File: rtl/flash_chunk_reader.sv
module flash_chunk_reader
  import fc_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = 16,
  parameter int FIFO_BYTES  = 128,
  parameter int SEM_TRIES   = 500,
  parameter int RETRY_DLY   = 1000,
  parameter int FLUSH_POLLS = 10000,
  parameter int ACT_POLLS   = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  output logic              done,
  output logic [2:0]        err_code,
  output logic              reg_valid,
  output logic              reg_write,
  output logic [2:0]        reg_sel,
  output logic [31:0]       reg_wdata,
  input  logic              reg_ready,
  input  logic [31:0]       reg_rdata,
  output logic              buf_valid,
  input  logic              buf_ready,
  output logic [LEN_W-3:0]  buf_addr,
  output logic [31:0]       buf_data
);

  localparam int OW   = $clog2(FIFO_BYTES);
  localparam int PW   = OW + 1;
  localparam int CW   = $clog2(FIFO_BYTES / 4) + 1;
  localparam int BAW  = LEN_W - 2;
  localparam int PM1  = (SEM_TRIES > FLUSH_POLLS) ? SEM_TRIES : FLUSH_POLLS;
  localparam int PMAX = (PM1 > ACT_POLLS) ? PM1 : ACT_POLLS;
  localparam int PCW  = $clog2(PMAX + 1);
  localparam int DW   = $clog2(RETRY_DLY + 1);

  typedef enum logic [4:0] {
    S_IDLE, S_SEM_RD, S_SEM_WAIT, S_PLAN,
    S_FL_STAT, S_FL_DRAIN, S_FL_POLL,
    S_ST_CMD, S_ST_ACT, S_ST_CNT, S_ST_DAT, S_ST_CHK,
    S_RD_ADDR, S_RD_CMD, S_RD_ACT,
    S_DR_RD, S_DR_WR,
    S_REL, S_DONE
  } st_e;

  st_e               state, flush_ret;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic [BAW-1:0]    word_idx;
  logic [PW-1:0]     piece_len;
  logic [CW-1:0]     drain_left;
  logic [PCW-1:0]    pcnt;
  logic              retried;
  logic [7:0]        stat_byte;
  logic [31:0]       word_q;
  fc_err_e           err;

  logic              hs;
  logic [CW-1:0]     fifo_cnt;
  logic              act_on;
  logic [PW-1:0]     pc_len;
  logic              pc_bad;
  logic [31:0]       swapped;
  logic [DW-1:0]     dly;

  assign hs       = reg_valid && reg_ready;
  assign fifo_cnt = reg_rdata[CW-1:0];
  assign act_on   = reg_rdata[ACT_BIT];

  fc_piece_calc #(.LEN_W(LEN_W), .FIFO_BYTES(FIFO_BYTES)) u_piece (
    .addr_lo   (cur_addr[OW-1:0]),
    .remain    (remain),
    .piece_len (pc_len),
    .piece_bad (pc_bad)
  );

  fc_byte_swap #(.BYTES(4)) u_swap (
    .din  (reg_rdata),
    .dout (swapped)
  );

  fc_delay_ctr #(.W(DW)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == S_SEM_WAIT),
    .count (dly)
  );

  // register port requests, one per state
  always_comb begin
    reg_valid = 1'b0;
    reg_write = 1'b0;
    reg_sel   = SEL_STAT;
    reg_wdata = '0;
    unique case (state)
      S_SEM_RD: begin
        reg_valid = 1'b1;
        reg_sel   = SEL_SEM;
      end
      S_FL_STAT, S_FL_POLL, S_ST_CNT: begin
        reg_valid = 1'b1;
        reg_sel   = SEL_STAT;
      end
      S_FL_DRAIN, S_ST_DAT, S_DR_RD: begin
        reg_valid = 1'b1;
        reg_sel   = SEL_DATA;
      end
      S_ST_CMD: begin
        reg_valid = 1'b1;
        reg_write = 1'b1;
        reg_sel   = SEL_CMD;
        reg_wdata = fc_cmd(OP_STATUS, 4'd0, 8'd4);
      end
      S_ST_ACT, S_RD_ACT: begin
        reg_valid = 1'b1;
        reg_sel   = SEL_CMD;
      end
      S_RD_ADDR: begin
        reg_valid = 1'b1;
        reg_write = 1'b1;
        reg_sel   = SEL_ADDR;
        reg_wdata = 32'(cur_addr);
      end
      S_RD_CMD: begin
        reg_valid = 1'b1;
        reg_write = 1'b1;
        reg_sel   = SEL_CMD;
        reg_wdata = fc_cmd(OP_FAST, 4'd4, 8'(piece_len));
      end
      S_REL: begin
        reg_valid = 1'b1;
        reg_write = 1'b1;
        reg_sel   = SEL_SEM;
        reg_wdata = '0;
      end
      default: ;
    endcase
  end

  assign buf_valid = (state == S_DR_WR);
  assign buf_addr  = word_idx;
  assign buf_data  = word_q;
  assign done      = (state == S_DONE);
  assign err_code  = err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      flush_ret  <= S_ST_CMD;
      cur_addr   <= '0;
      remain     <= '0;
      word_idx   <= '0;
      piece_len  <= '0;
      drain_left <= '0;
      pcnt       <= '0;
      retried    <= 1'b0;
      stat_byte  <= '0;
      word_q     <= '0;
      err        <= FC_OK;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start) begin
            cur_addr <= start_addr;
            remain   <= start_len;
            word_idx <= '0;
            pcnt     <= '0;
            err      <= FC_OK;
            state    <= S_SEM_RD;
          end
        end

        S_SEM_RD: begin
          if (hs) begin
            if (reg_rdata == '0) begin
              state <= S_PLAN;
            end else if (pcnt == PCW'(SEM_TRIES - 1)) begin
              err   <= FC_ERR_SEM;
              state <= S_DONE;
            end else begin
              pcnt  <= pcnt + 1'b1;
              state <= S_SEM_WAIT;
            end
          end
        end

        S_SEM_WAIT: begin
          if (dly == DW'(RETRY_DLY - 1)) state <= S_SEM_RD;
        end

        S_PLAN: begin
          if (remain == '0) begin
            state <= S_REL;
          end else if (pc_bad) begin
            err   <= FC_ERR_LEN;
            state <= S_REL;
          end else begin
            piece_len <= pc_len;
            retried   <= 1'b0;
            flush_ret <= S_ST_CMD;
            state     <= S_FL_STAT;
          end
        end

        S_FL_STAT: begin
          if (hs) begin
            if (fifo_cnt == '0) begin
              state <= flush_ret;
            end else begin
              drain_left <= fifo_cnt;
              state      <= S_FL_DRAIN;
            end
          end
        end

        S_FL_DRAIN: begin
          if (hs) begin
            if (drain_left == CW'(1)) begin
              pcnt  <= '0;
              state <= S_FL_POLL;
            end
            drain_left <= drain_left - 1'b1;
          end
        end

        S_FL_POLL: begin
          if (hs) begin
            if (fifo_cnt == '0) begin
              state <= flush_ret;
            end else if (pcnt == PCW'(FLUSH_POLLS - 1)) begin
              err   <= FC_ERR_FIFO;
              state <= S_REL;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        end

        S_ST_CMD: begin
          if (hs) begin
            pcnt  <= '0;
            state <= S_ST_ACT;
          end
        end

        S_ST_ACT: begin
          if (hs) begin
            if (!act_on) begin
              state <= S_ST_CNT;
            end else if (pcnt == PCW'(ACT_POLLS - 1)) begin
              err   <= FC_ERR_ACT;
              state <= S_REL;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        end

        S_ST_CNT: begin
          if (hs) begin
            if (fifo_cnt != '0) begin
              state <= S_ST_DAT;
            end else if (!retried) begin
              retried   <= 1'b1;
              flush_ret <= S_ST_CMD;
              state     <= S_FL_STAT;
            end else begin
              err   <= FC_ERR_WIP;
              state <= S_REL;
            end
          end
        end

        S_ST_DAT: begin
          if (hs) begin
            stat_byte <= reg_rdata[31:24];
            flush_ret <= S_ST_CHK;
            state     <= S_FL_STAT;
          end
        end

        S_ST_CHK: begin
          if (stat_byte[0]) begin
            err   <= FC_ERR_WIP;
            state <= S_REL;
          end else begin
            state <= S_RD_ADDR;
          end
        end

        S_RD_ADDR: begin
          if (hs) state <= S_RD_CMD;
        end

        S_RD_CMD: begin
          if (hs) begin
            pcnt  <= '0;
            state <= S_RD_ACT;
          end
        end

        S_RD_ACT: begin
          if (hs) begin
            if (!act_on) begin
              drain_left <= CW'(piece_len >> 2);
              state      <= S_DR_RD;
            end else if (pcnt == PCW'(ACT_POLLS - 1)) begin
              err   <= FC_ERR_ACT;
              state <= S_REL;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        end

        S_DR_RD: begin
          if (hs) begin
            word_q <= swapped;
            state  <= S_DR_WR;
          end
        end

        S_DR_WR: begin
          if (buf_ready) begin
            word_idx   <= word_idx + 1'b1;
            drain_left <= drain_left - 1'b1;
            if (drain_left == CW'(1)) begin
              cur_addr <= cur_addr + ADDR_W'(piece_len);
              remain   <= remain - LEN_W'(piece_len);
              state    <= S_PLAN;
            end else begin
              state <= S_DR_RD;
            end
          end
        end

        S_REL: begin
          if (hs) state <= S_DONE;
        end

        S_DONE: state <= S_IDLE;

        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
  parameter int FIFO_BYTES = 128,
  parameter int BAW        = 14,
  localparam int OW = $clog2(FIFO_BYTES)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_valid,
  input logic           reg_ready,
  input logic           reg_write,
  input logic [2:0]     reg_sel,
  input logic [31:0]    reg_wdata,
  input logic [31:0]    reg_rdata,
  input logic           buf_valid,
  input logic           buf_ready,
  input logic [BAW-1:0] buf_addr,
  input logic [31:0]    buf_data,
  input logic           done
);

  logic          held;
  logic [OW-1:0] last_off;
  logic          hs;
  logic          fast_cmd;
  logic [7:0]    rcnt;

  assign hs       = reg_valid && reg_ready;
  assign rcnt     = reg_wdata[19:12];
  assign fast_cmd = hs && reg_write && (reg_sel == 3'd1) && reg_wdata[31] &&
                    (reg_wdata[7:0] == 8'h0B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= 1'b0;
      last_off <= '0;
    end else begin
      if (hs && !reg_write && reg_sel == 3'd0 && reg_rdata == 32'd0) held <= 1'b1;
      if (hs && reg_write && reg_sel == 3'd0) held <= 1'b0;
      if (hs && reg_write && reg_sel == 3'd2) last_off <= reg_wdata[OW-1:0];
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_ready |=> reg_valid && $stable(reg_sel) &&
                                $stable(reg_write) && $stable(reg_wdata));

  assert_buf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && !buf_ready |=> buf_valid && $stable(buf_data) && $stable(buf_addr));

  assert_buf_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> held);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_release_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && reg_write && reg_sel == 3'd0) |-> held);

  assert_done_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !held);

  assert_piece_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fast_cmd |-> held && (rcnt != 8'd0) && (rcnt[1:0] == 2'b00) &&
                 ((int'(last_off) + int'(rcnt)) <= FIFO_BYTES));

endmodule

bind flash_chunk_reader fc_checker #(.FIFO_BYTES(FIFO_BYTES), .BAW(LEN_W - 2)) u_fc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_valid (reg_valid),
  .reg_ready (reg_ready),
  .reg_write (reg_write),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .buf_valid (buf_valid),
  .buf_ready (buf_ready),
  .buf_addr  (buf_addr),
  .buf_data  (buf_data),
  .done      (done)
);

// File: tb/flash_chunk_reader_test.sv
`timescale 1ns/1ps
module flash_chunk_reader_test;

  localparam int RDLY = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic [15:0] start_len = '0;
  logic        done;
  logic [2:0]  err_code;
  logic        reg_valid, reg_write, reg_ready;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        buf_valid, buf_ready;
  logic [13:0] buf_addr;
  logic [31:0] buf_data;

  always #2.5 clk = ~clk;

  flash_chunk_reader #(
    .SEM_TRIES(500), .RETRY_DLY(RDLY), .FLUSH_POLLS(16), .ACT_POLLS(40)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_len(start_len), .done(done), .err_code(err_code),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
    .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_addr(buf_addr),
    .buf_data(buf_data)
  );

  // knobs, written only by tasks
  int sem_busy_n = 0, stale_n = 0, empty_n = 0;
  bit wip_k = 0, act_stuck = 0, fifo_stuck = 0, reg_slow = 0, buf_bp = 0;

  // engine model state, written only by the model
  int cyc = 0, act_timer = 0, wp = 0, rp = 0;
  int sem_seen = 0, sem_reads = 0, rel_cnt = 0, stat_cmds = 0, fast_cmds = 0;
  int empties = 0, min_gap = 1000000, last_sem = -1, cap_n = 0;
  bit sem_held = 0, act_hold = 0;
  logic [23:0] addr_m = '0;
  logic [31:0] fifo [64];
  int plog [8];
  logic [31:0] cap [256];

  int checks = 0, fails = 0;

  function automatic logic [7:0] fbyte(input int a);
    return 8'((a * 29 + 11) ^ (a >> 8));
  endfunction

  function automatic logic [31:0] exp_word(input int a);
    return {fbyte(a + 3), fbyte(a + 2), fbyte(a + 1), fbyte(a)};
  endfunction

  assign reg_ready = !(reg_slow && cyc[0]);
  assign buf_ready = !(buf_bp && (cyc % 3 == 0));

  always_comb begin
    case (reg_sel)
      3'd0:    reg_rdata = (sem_held || sem_seen < sem_busy_n) ? 32'd1 : 32'd0;
      3'd1:    reg_rdata = {(act_timer > 0) || act_hold, 31'b0};
      3'd3:    reg_rdata = 32'(wp - rp);
      3'd4:    reg_rdata = fifo[rp & 63];
      default: reg_rdata = 32'd0;
    endcase
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (act_timer > 0) act_timer <= act_timer - 1;
    if (start) begin
      sem_seen <= 0; sem_reads <= 0; rel_cnt <= 0; stat_cmds <= 0;
      fast_cmds <= 0; empties <= 0; act_hold <= 0; min_gap <= 1000000;
      last_sem <= -1; cap_n <= 0; rp <= 0; wp <= stale_n; sem_held <= 0;
      for (int k = 0; k < stale_n; k++) fifo[k] <= 32'hBAD0_0000 + k;
    end
    if (reg_valid && reg_ready) begin
      case (reg_sel)
        3'd0: begin
          if (reg_write) begin
            sem_held <= 0;
            rel_cnt  <= rel_cnt + 1;
          end else begin
            if (sem_seen < sem_busy_n) sem_seen <= sem_seen + 1;
            else sem_held <= 1;
            sem_reads <= sem_reads + 1;
            if (last_sem >= 0 && cyc - last_sem < min_gap) min_gap <= cyc - last_sem;
            last_sem <= cyc;
          end
        end
        3'd1: if (reg_write && reg_wdata[31]) begin
          act_timer <= 3;
          if (reg_wdata[7:0] == 8'h05) begin
            stat_cmds <= stat_cmds + 1;
            if (empties < empty_n) empties <= empties + 1;
            else begin
              fifo[wp & 63] <= {(wip_k ? 8'h03 : 8'h02), 24'h0};
              wp <= wp + 1;
            end
          end else if (reg_wdata[7:0] == 8'h0B) begin
            if (fast_cmds < 8) plog[fast_cmds] <= int'(reg_wdata[19:12]);
            fast_cmds <= fast_cmds + 1;
            if (act_stuck) act_hold <= 1;
            for (int k = 0; k < int'(reg_wdata[19:14]); k++)
              fifo[(wp + k) & 63] <= {fbyte(int'(addr_m) + 4*k), fbyte(int'(addr_m) + 4*k + 1),
                                      fbyte(int'(addr_m) + 4*k + 2), fbyte(int'(addr_m) + 4*k + 3)};
            wp <= wp + int'(reg_wdata[19:14]);
          end
        end
        3'd2: if (reg_write) addr_m <= reg_wdata[23:0];
        3'd4: if (!reg_write && !fifo_stuck) rp <= rp + 1;
        default: ;
      endcase
    end
    if (buf_valid && buf_ready) begin
      if (buf_addr < 256) cap[buf_addr] <= buf_data;
      cap_n <= cap_n + 1;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic defaults();
    sem_busy_n = 0; stale_n = 0; empty_n = 0; wip_k = 0; act_stuck = 0;
    fifo_stuck = 0; reg_slow = 0; buf_bp = 0;
  endtask

  task automatic run(input int off, input int len, output int code);
    bit seen = 0;
    @(negedge clk);
    start_addr = 24'(off);
    start_len  = 16'(len);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    if (!seen) begin
      fails++;
      $display("FAIL watchdog transfer at %0d actual=hung expected=done", off);
    end
    code = int'(err_code);
    @(negedge clk);
  endtask

  task automatic chk_data(input string tag, input int off, input int len);
    int bad = 0;
    for (int k = 0; k < len / 4; k++) if (cap[k] !== exp_word(off + 4*k)) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic t_reset();
    chk("R10 reset done", done, 0);
    chk("R10 reset reg_valid", reg_valid, 0);
    chk("R10 reset buf_valid", buf_valid, 0);
  endtask

  task automatic t_aligned();
    int c;
    defaults();
    run(0, 64, c);
    chk("R9 aligned code", c, 0);
    chk("R8 aligned words", cap_n, 16);
    chk_data("R8 aligned data", 0, 64);
    chk("R9 aligned release", rel_cnt, 1);
    chk("R2 aligned pieces", fast_cmds, 1);
    chk("R5 aligned status cmds", stat_cmds, 1);
  endtask

  task automatic t_cross();
    int c;
    defaults();
    reg_slow = 1;
    run(100, 200, c);
    chk("R2 cross code", c, 0);
    chk("R2 cross pieces", fast_cmds, 3);
    chk("R2 piece0", plog[0], 28);
    chk("R2 piece1", plog[1], 128);
    chk("R2 piece2", plog[2], 44);
    chk_data("R8 cross data", 100, 200);
  endtask

  task automatic t_stale_bp();
    int c;
    defaults();
    stale_n = 3; buf_bp = 1;
    run(256, 48, c);
    chk("R4 stale code", c, 0);
    chk("R8 bp words", cap_n, 12);
    chk_data("R4 stale data", 256, 48);
  endtask

  task automatic t_busy();
    int c;
    defaults();
    empty_n = 1;
    run(8, 16, c);
    chk("R5 busy once code", c, 0);
    chk("R5 busy once status cmds", stat_cmds, 2);
    chk_data("R5 busy once data", 8, 16);
    empty_n = 2;
    run(8, 16, c);
    chk("R5 busy twice code", c, 3);
    chk("R5 busy twice release", rel_cnt, 1);
    chk("R5 busy twice no read", fast_cmds, 0);
  endtask

  task automatic t_wip();
    int c;
    defaults();
    wip_k = 1;
    run(0, 32, c);
    chk("R6 wip code", c, 3);
    chk("R6 wip no fast read", fast_cmds, 0);
    chk("R6 wip release", rel_cnt, 1);
  endtask

  task automatic t_act();
    int c;
    defaults();
    act_stuck = 1;
    run(0, 32, c);
    chk("R7 act code", c, 4);
    chk("R7 act no words", cap_n, 0);
    chk("R7 act release", rel_cnt, 1);
  endtask

  task automatic t_fifo();
    int c;
    defaults();
    stale_n = 2; fifo_stuck = 1;
    run(0, 32, c);
    chk("R4 fifo code", c, 2);
    chk("R4 fifo no status cmd", stat_cmds, 0);
    chk("R4 fifo release", rel_cnt, 1);
  endtask

  task automatic t_len();
    int c;
    defaults();
    run(0, 6, c);
    chk("R3 len6 code", c, 1);
    chk("R3 len6 no words", cap_n, 0);
    chk("R3 len6 release", rel_cnt, 1);
    run(126, 8, c);
    chk("R3 edge2 code", c, 1);
    chk("R3 edge2 no read", fast_cmds, 0);
  endtask

  task automatic t_sem();
    int c;
    defaults();
    sem_busy_n = 3;
    run(0, 16, c);
    chk("R1 retry code", c, 0);
    chk("R1 retry reads", sem_reads, 4);
    chk("R1 retry gap", min_gap, RDLY + 1);
    sem_busy_n = 100000;
    run(0, 16, c);
    chk("R1 refuse code", c, 5);
    chk("R1 refuse reads", sem_reads, 500);
    chk("R1 refuse no release", rel_cnt, 0);
  endtask

  task automatic t_zero();
    int c;
    defaults();
    run(40, 0, c);
    chk("R9 zero code", c, 0);
    chk("R9 zero release", rel_cnt, 1);
    chk("R9 zero no read", fast_cmds, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_cross();
    t_stale_bp();
    t_busy();
    t_wip();
    t_act();
    t_fifo();
    t_len();
    t_sem();
    t_zero();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule